// File: doc/BRIEF.md
# I2C Slave Byte Receiver

This block is the receive side of an I2C slave. It runs on a system clock that is much faster than the bus. It samples the SCL and SDA lines through a glitch filter, finds START and STOP conditions, and shifts bytes in MSB first. Each byte is compared against a programmable own address, which is either 7 bits or 10 bits wide. When a byte is accepted, it is moved out of the shift register into a single holding buffer. The block then raises an interrupt flag and acknowledges the byte by pulling SDA low in the ninth clock slot.

Received bytes leave the block on a valid/ready stream. `rx_valid` goes high when the holding buffer is filled. `rx_data` then stays stable until the consumer takes the byte with `rx_ready` high while `rx_valid` is high. The shift register keeps filling while the buffer waits, so the consumer has a full byte time to respond. If a further byte completes while the buffer is still unaccepted, that new byte is dropped and not acknowledged, and an overflow flag is raised. Control inputs (mode, own address, general-call enable, interrupt clear) and status outputs are plain level signals.

Top module: `i2c_slave_rx`

## Requirements
- R1: `mode` selects the operation. 4'b0110 is 7-bit slave, 4'b0111 is 10-bit slave, 4'b1110 is 7-bit slave with interrupts on START/STOP, and 4'b1111 is 10-bit slave with interrupts on START/STOP. With any other code the block stores no byte, never acknowledges, raises no interrupt and leaves the START/STOP status unchanged.
- R2: After reset, `st_start` and `st_stop` are both 0. A START (SDA falling while SCL is high) sets `st_start` and clears `st_stop`. A STOP (SDA rising while SCL is high) does the reverse. The two are never high together.
- R3: In the two START/STOP interrupt modes, each START and each STOP sets `irq`. In the two plain modes they change only the status bits.
- R4: In 7-bit mode, the first byte after a START is accepted when bits [7:1] equal `own_addr[6:0]`. On acceptance the byte is stored and acknowledged, `st_data` becomes 0 and `st_rw` takes bit 0 of the byte. After a read address (bit 0 = 1), no further bytes are stored.
- R5: In 7-bit mode with `gc_en` = 1, a first byte of 8'h00 is also accepted as a write address. With `gc_en` = 0 it is refused.
- R6: A refused address byte is not acknowledged (SDA stays released) and is not stored. Every byte after it is ignored until the next START.
- R7: After an accepted write address, each data byte is shifted in MSB first, stored, acknowledged, and sets `st_data` to 1.
- R8: In 10-bit mode, the first byte must equal {5'b11110, own_addr[9:8], 1'b0}. When it does, it is stored, acknowledged and sets `st_upd`. The second byte must equal `own_addr[7:0]`. When it does, it is stored, acknowledged and clears `st_upd`, and the bytes after it are data. A mismatching second byte is refused as in R6.
- R9: Storing a byte sets `rx_valid` and places the byte on `rx_data`. A cycle with `rx_valid` and `rx_ready` both high takes the byte and clears `rx_valid`, unless a new byte is stored in that same cycle.
- R10: A byte that would be accepted but completes while `rx_valid` is high and `rx_ready` is low is dropped. `rx_data` keeps the old byte, `ovf` is set and the byte is not acknowledged. A taken byte clears `ovf`.
- R11: When a byte completes in the same cycle that the held byte is taken, the new byte is stored, `rx_valid` stays high, `ovf` stays 0 and the byte is acknowledged.
- R12: Every stored byte sets `irq`. `irq_clr` clears it, and a set in the same cycle wins over the clear.
- R13: A pulse on SCL or SDA shorter than `FILT_LEN` clock cycles is not seen. For example, a 2-cycle low pulse on SDA while SCL is high does not count as a START.
- R14: `sda_oe` = 1 means SDA is driven low, and `sda_oe` = 0 means SDA is released. The block asserts `sda_oe` only in the acknowledge slot (the ninth SCL clock), so a 1 on the bus is always a released line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line as seen at the pin |
| sda_i | input | 1 | SDA line as seen at the pin |
| sda_oe | output | 1 | 1 = pull SDA low (open-drain enable) |
| mode | input | 4 | Operating mode code (R1) |
| gc_en | input | 1 | Accept general call address 8'h00 |
| own_addr | input | 10 | Own slave address; the 7-bit modes use [6:0] |
| rx_data | output | 8 | Held received byte |
| rx_valid | output | 1 | Holding buffer is full |
| rx_ready | input | 1 | Consumer takes the held byte |
| irq | output | 1 | Sticky interrupt flag |
| irq_clr | input | 1 | Clear the interrupt flag |
| ovf | output | 1 | Receive overflow flag |
| st_start | output | 1 | Last bus condition seen was START |
| st_stop | output | 1 | Last bus condition seen was STOP |
| st_data | output | 1 | Last stored byte was data (1) or address (0) |
| st_rw | output | 1 | Direction bit of the last 7-bit address |
| st_upd | output | 1 | 10-bit address is half received |

## Verification
Two functions can fall in the same cycle. One is a byte completing in the shift register. The other is the consumer taking the previously held byte. The bench first measures, at the ports, the fixed number of clock cycles from its own SCL rising drive to the overflow flag appearing. It then replays the same eighth bit and holds `rx_ready` high for exactly the cycle in which the byte completes. The pass condition is that the new byte replaces the old one, `rx_valid` stays high, no overflow is raised and the byte receives an acknowledge.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;

  localparam logic [3:0] MODE_S7     = 4'b0110;
  localparam logic [3:0] MODE_S10    = 4'b0111;
  localparam logic [3:0] MODE_S7_SP  = 4'b1110;
  localparam logic [3:0] MODE_S10_SP = 4'b1111;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR1,
    PH_ADDR2,
    PH_DATA
  } phase_t;
endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN) + 1;

  logic [1:0]    sync_r;
  logic [CW-1:0] run_cnt;
  logic          q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_r  <= 2'b11;
      run_cnt <= '0;
      q_r     <= 1'b1;
    end else begin
      sync_r <= {sync_r[0], din};
      if (sync_r[1] == q_r) begin
        run_cnt <= '0;
      end else if (run_cnt == CW'(FILT_LEN - 1)) begin
        q_r     <= sync_r[1];
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  assign dout = q_r;

  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_r[1] == q_r) |=> $stable(q_r)); // R13
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_srx_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_in,
  input  phase_t            phase,
  input  logic              ten_bit,
  input  logic              gc_en,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              hit
);
  logic [BYTE_W-1:0] ten_hdr;
  logic              seven_hit;
  logic              gcall_hit;

  assign ten_hdr   = {5'b11110, own_addr[9:8], 1'b0};
  assign seven_hit = (byte_in[7:1] == own_addr[6:0]);
  assign gcall_hit = gc_en && (byte_in == '0);

  always_comb begin
    unique case (phase)
      PH_ADDR1: hit = ten_bit ? (byte_in == ten_hdr) : (seven_hit || gcall_hit);
      PH_ADDR2: hit = ten_bit && (byte_in == own_addr[7:0]);
      PH_DATA:  hit = 1'b1;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2c_srx_pkg::*;
#(
  parameter int FILT_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [3:0]        mode,
  input  logic              gc_en,
  input  logic [ADDR_W-1:0] own_addr,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              irq,
  input  logic              irq_clr,
  output logic              ovf,
  output logic              st_start,
  output logic              st_stop,
  output logic              st_data,
  output logic              st_rw,
  output logic              st_upd
);
  localparam int LINES = 2;
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

  // line filtering, index 0 = SCL, index 1 = SDA
  logic [LINES-1:0] raw_l, filt_l;
  assign raw_l = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_filt
    i2c_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_l[g]),
      .dout (filt_l[g])
    );
  end

  logic scl_f, sda_f, scl_p, sda_p;
  assign scl_f = filt_l[0];
  assign sda_f = filt_l[1];

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_f && !scl_p;
  assign scl_fall = !scl_f && scl_p;
  assign start_c  = scl_f && scl_p && sda_p && !sda_f;
  assign stop_c   = scl_f && scl_p && !sda_p && sda_f;

  // mode decode
  logic mode_ok, ten_bit, sp_irq;
  assign ten_bit = (mode == MODE_S10) || (mode == MODE_S10_SP);
  assign sp_irq  = (mode == MODE_S7_SP) || (mode == MODE_S10_SP);
  assign mode_ok = (mode == MODE_S7) || (mode == MODE_S7_SP) || ten_bit;

  // bit engine
  phase_t            phase, nxt_phase;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] full_byte;
  logic [CNT_W-1:0]  bit_cnt;
  logic              ack_clk, accept_q, oe_r;
  logic              hit, byte_done, want, pop, store, ovf_evt;

  assign full_byte = {shreg[BYTE_W-2:0], sda_f};
  assign byte_done = scl_rise && (bit_cnt == LAST_BIT);

  i2c_addr_match u_match (
    .byte_in (full_byte),
    .phase   (phase),
    .ten_bit (ten_bit),
    .gc_en   (gc_en),
    .own_addr(own_addr),
    .hit     (hit)
  );

  assign want    = byte_done && hit && mode_ok;
  assign pop     = rx_valid && rx_ready;
  assign store   = want && (!rx_valid || pop);
  assign ovf_evt = want && rx_valid && !pop;

  always_comb begin
    unique case (phase)
      PH_ADDR1: begin
        if (!store)       nxt_phase = PH_IDLE;
        else if (ten_bit) nxt_phase = PH_ADDR2;
        else              nxt_phase = full_byte[0] ? PH_IDLE : PH_DATA;
      end
      PH_ADDR2, PH_DATA: nxt_phase = store ? PH_DATA : PH_IDLE;
      default:           nxt_phase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
      phase    <= PH_IDLE;
      shreg    <= '0;
      bit_cnt  <= '0;
      ack_clk  <= 1'b0;
      accept_q <= 1'b0;
      oe_r     <= 1'b0;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
      if (start_c || stop_c) begin
        bit_cnt  <= '0;
        ack_clk  <= 1'b0;
        accept_q <= 1'b0;
        oe_r     <= 1'b0;
        phase    <= (start_c && mode_ok) ? PH_ADDR1 : PH_IDLE;
      end else begin
        if (scl_rise) begin
          if (bit_cnt < ACK_SLOT) begin
            shreg   <= full_byte;
            bit_cnt <= bit_cnt + 1'b1;
          end else begin
            ack_clk <= 1'b1;
          end
        end
        if (scl_fall && (bit_cnt == ACK_SLOT)) begin
          if (!ack_clk) begin
            oe_r <= accept_q;
          end else begin
            oe_r    <= 1'b0;
            bit_cnt <= '0;
            ack_clk <= 1'b0;
          end
        end
        if (byte_done) begin
          accept_q <= store;
          phase    <= nxt_phase;
        end
      end
    end
  end

  assign sda_oe = oe_r;

  // holding buffer, flags and status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
      ovf      <= 1'b0;
      irq      <= 1'b0;
      st_start <= 1'b0;
      st_stop  <= 1'b0;
      st_data  <= 1'b0;
      st_rw    <= 1'b0;
      st_upd   <= 1'b0;
    end else begin
      if (store) begin
        rx_data  <= full_byte;
        rx_valid <= 1'b1;
      end else if (pop) begin
        rx_valid <= 1'b0;
      end

      if (ovf_evt)  ovf <= 1'b1;
      else if (pop) ovf <= 1'b0;

      if (store || (sp_irq && (start_c || stop_c))) irq <= 1'b1;
      else if (irq_clr)                             irq <= 1'b0;

      if (mode_ok && start_c) begin
        st_start <= 1'b1;
        st_stop  <= 1'b0;
      end else if (mode_ok && stop_c) begin
        st_start <= 1'b0;
        st_stop  <= 1'b1;
      end

      if (store) begin
        st_data <= (phase == PH_DATA);
        if (phase == PH_ADDR1) begin
          st_rw  <= ten_bit ? 1'b0 : full_byte[0];
          st_upd <= ten_bit;
        end
        if (phase == PH_ADDR2) st_upd <= 1'b0;
      end
    end
  end

  AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_start && st_stop)); // R2
  AST_ACK_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (bit_cnt == ACK_SLOT)); // R14
  AST_OVF_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ($stable(rx_data) && ovf && rx_valid)); // R10
  AST_NO_ACK_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> !sda_oe); // R10
  AST_STORE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> (irq && rx_valid)); // R12
endmodule

// File: tb/tb_i2c_slave_rx.sv
`timescale 1ns/100ps
module tb_i2c_slave_rx;
  import i2c_srx_pkg::*;

  localparam int T = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic [3:0] mode = MODE_S7;
  logic gc_en = 1'b0;
  logic [9:0] own_addr = 10'h02A;
  logic [7:0] rx_data;
  logic rx_valid, rx_ready = 1'b0, irq, irq_clr = 1'b0, ovf;
  logic st_start, st_stop, st_data, st_rw, st_upd;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_slave_rx dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .mode(mode), .gc_en(gc_en), .own_addr(own_addr), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq), .irq_clr(irq_clr),
    .ovf(ovf), .st_start(st_start), .st_stop(st_stop), .st_data(st_data),
    .st_rw(st_rw), .st_upd(st_upd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(T); scl_m = 1'b1; wt(T);
    sda_m = 1'b0; wt(T); scl_m = 1'b0; wt(T);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(T); scl_m = 1'b1; wt(T); sda_m = 1'b1; wt(T);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wt(T); scl_m = 1'b1; wt(T); scl_m = 1'b0; wt(2);
  endtask

  task automatic get_ack(output logic a);
    sda_m = 1'b1; wt(T); scl_m = 1'b1; wt(T/2);
    a = (sda_line == 1'b0);
    wt(T/2); scl_m = 1'b0; wt(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    get_ack(a);
  endtask

  task automatic take_byte();
    rx_ready = 1'b1; wt(1); rx_ready = 1'b0; wt(1);
  endtask

  task automatic clear_irq();
    irq_clr = 1'b1; wt(1); irq_clr = 1'b0; wt(1);
  endtask

  task automatic t_reset();
    chk("R2 reset st_start", st_start, 0);
    chk("R2 reset st_stop", st_stop, 0);
    chk("R9 reset rx_valid", rx_valid, 0);
    chk("R12 reset irq", irq, 0);
    chk("R10 reset ovf", ovf, 0);
    chk("R14 reset sda_oe", sda_oe, 0);
  endtask

  task automatic t_seven_write();
    logic a;
    mode = MODE_S7; own_addr = 10'h02A;
    bus_start();
    chk("R2 start status", {st_start, st_stop}, 2'b10);
    chk("R3 plain mode start no irq", irq, 0);
    send_byte(8'h54, a);
    chk("R4 addr ack", a, 1);
    chk("R9 addr valid", rx_valid, 1);
    chk("R4 addr byte", rx_data, 8'h54);
    chk("R4 st_data addr", st_data, 0);
    chk("R4 st_rw write", st_rw, 0);
    chk("R12 irq on store", irq, 1);
    take_byte();
    chk("R9 taken", rx_valid, 0);
    clear_irq();
    chk("R12 irq cleared", irq, 0);
    send_byte(8'hA5, a);
    chk("R7 data ack", a, 1);
    chk("R7 data byte", rx_data, 8'hA5);
    chk("R7 st_data", st_data, 1);
    take_byte(); clear_irq();
    send_byte(8'h3C, a);
    chk("R7 second data byte", rx_data, 8'h3C);
    take_byte(); clear_irq();
    bus_stop();
    chk("R2 stop status", {st_start, st_stop}, 2'b01);
    chk("R3 plain mode stop no irq", irq, 0);
  endtask

  task automatic t_mismatch();
    logic a;
    bus_start();
    send_byte(8'h56, a);
    chk("R6 mismatch nack", a, 0);
    chk("R6 mismatch not stored", rx_valid, 0);
    send_byte(8'h54, a);
    chk("R6 later byte ignored ack", a, 0);
    chk("R6 later byte ignored store", rx_valid, 0);
    chk("R6 no irq", irq, 0);
    bus_stop();
  endtask

  task automatic t_gencall();
    logic a;
    gc_en = 1'b0;
    bus_start(); send_byte(8'h00, a);
    chk("R5 gc off nack", a, 0);
    chk("R5 gc off not stored", rx_valid, 0);
    bus_stop();
    gc_en = 1'b1;
    bus_start(); send_byte(8'h00, a);
    chk("R5 gc on ack", a, 1);
    chk("R5 gc byte stored", {rx_valid, rx_data}, {1'b1, 8'h00});
    take_byte();
    send_byte(8'h77, a);
    chk("R5 gc data stored", rx_data, 8'h77);
    take_byte(); clear_irq(); bus_stop(); gc_en = 1'b0;
  endtask

  task automatic t_read();
    logic a;
    bus_start(); send_byte(8'h55, a);
    chk("R4 read addr ack", a, 1);
    chk("R4 st_rw read", st_rw, 1);
    take_byte(); clear_irq();
    send_byte(8'hFF, a);
    chk("R4 after read no ack", a, 0);
    chk("R4 after read no store", rx_valid, 0);
    bus_stop();
  endtask

  task automatic t_ten();
    logic a;
    mode = MODE_S10; own_addr = 10'h2B7;
    bus_start(); send_byte(8'hF4, a);
    chk("R8 hi byte ack", a, 1);
    chk("R8 hi byte stored", rx_data, 8'hF4);
    chk("R8 st_upd set", st_upd, 1);
    take_byte();
    send_byte(8'hB7, a);
    chk("R8 lo byte ack", a, 1);
    chk("R8 st_upd clear", st_upd, 0);
    chk("R8 lo byte addr", st_data, 0);
    take_byte();
    send_byte(8'h3C, a);
    chk("R8 data after 10b", {a, rx_data, st_data}, {1'b1, 8'h3C, 1'b1});
    take_byte(); bus_stop();
    bus_start(); send_byte(8'hF4, a); take_byte();
    send_byte(8'hB6, a);
    chk("R8 wrong lo nack", a, 0);
    chk("R8 wrong lo not stored", rx_valid, 0);
    bus_stop(); clear_irq();
  endtask

  task automatic t_sp_irq();
    mode = MODE_S7_SP; own_addr = 10'h02A;
    bus_start();
    chk("R3 irq on start", irq, 1);
    clear_irq();
    bus_stop();
    chk("R3 irq on stop", irq, 1);
    clear_irq();
  endtask

  task automatic t_glitch();
    mode = MODE_S7_SP;
    sda_m = 1'b0; wt(2); sda_m = 1'b1; wt(T);
    chk("R13 glitch no start", st_start, 0);
    chk("R13 glitch no irq", irq, 0);
    mode = MODE_S7;
  endtask

  task automatic t_overflow();
    logic a;
    mode = MODE_S7;
    bus_start(); send_byte(8'h54, a);
    send_byte(8'h11, a);
    chk("R10 overflow nack", a, 0);
    chk("R10 ovf set", ovf, 1);
    chk("R10 buffer kept", rx_data, 8'h54);
    take_byte();
    chk("R10 ovf cleared by take", {ovf, rx_valid}, 2'b00);
    clear_irq(); bus_stop();
  endtask

  task automatic t_same_cycle();
    logic a;
    int n;
    mode = MODE_S7;
    bus_start(); send_byte(8'h54, a);
    for (int i = 7; i >= 1; i--) send_bit(1'(8'h66 >> i));
    sda_m = 1'b0; wt(T); scl_m = 1'b1;
    n = 0;
    do begin
      @(posedge clk); n++; @(negedge clk);
    end while (!ovf && n < 100);
    wt(T); scl_m = 1'b0; wt(2);
    get_ack(a);
    take_byte(); clear_irq(); bus_stop();

    bus_start(); send_byte(8'h54, a);
    for (int i = 7; i >= 1; i--) send_bit(1'(8'h66 >> i));
    sda_m = 1'b0; wt(T); scl_m = 1'b1;
    repeat (n - 1) @(posedge clk);
    @(negedge clk) rx_ready = 1'b1;
    @(posedge clk);
    @(negedge clk) rx_ready = 1'b0;
    wt(2);
    chk("R11 still valid", rx_valid, 1);
    chk("R11 new byte held", rx_data, 8'h66);
    chk("R11 no overflow", ovf, 0);
    wt(T); scl_m = 1'b0; wt(2);
    get_ack(a);
    chk("R11 ack", a, 1);
    take_byte(); clear_irq(); bus_stop();
  endtask

  task automatic t_mode_off();
    logic a;
    mode = 4'b0000;
    bus_start();
    chk("R1 off no start status", st_start, 0);
    send_byte(8'h54, a);
    chk("R1 off nack", a, 0);
    chk("R1 off no store", rx_valid, 0);
    chk("R1 off no irq", irq, 0);
    bus_stop();
    mode = MODE_S7;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    wt(4); rst_n = 1'b1; wt(4);
    t_reset();
    t_seven_write();
    t_glitch();
    t_mismatch();
    t_gencall();
    t_read();
    t_ten();
    t_sp_irq();
    t_overflow();
    t_same_cycle();
    t_mode_off();
    finish_run();
  end
endmodule